// File: doc/BRIEF.md
# Single-Cell Fault-Injecting RAM

This block is a synchronous single-port RAM with configurable address and data widths. One bit of one word can be turned into a faulty memory cell. The fault type is chosen at run time, and the faulty cell then misbehaves on the operations that sensitise it. The block stands in for a real memory when a built-in self-test engine or a test algorithm is exercised. Each fault model gives a known, repeatable failure signature that the test under development has to find.

The faulty cell's state is held in a dedicated register, apart from the word storage, so the storage itself can map onto block RAM. The target address, target bit and fault code are captured while reset is high and stay fixed until the next reset. Reads return data one cycle after the request. With code 0, or any code outside 1..8, the block is an ideal RAM.

Top module: `fault_ram`

## Requirements
- R1: With fault code 0, or any code from 9 to 15, a read returns the last word written to that address on `rd_data` one cycle after `rd_en` is sampled. `rd_data` holds its value in every cycle that performs no read.
- R2: When `wr_en` and `rd_en` are both high, only the write is performed and `rd_data` keeps its previous value.
- R3: Code 1 (stuck-at-0) and code 2 (stuck-at-1) make the target bit read 0 or 1 respectively, whatever has been written.
- R4: Code 3 (rising transition fault): a write of 1 to the target bit while it holds 0 leaves it at 0. All other writes take effect.
- R5: Code 4 (falling transition fault): a write of 0 to the target bit while it holds 1 leaves it at 1. All other writes take effect.
- R6: Code 5 (read disturb): a read of the target bit returns the inverse of the stored value, and the stored value becomes that inverse.
- R7: Code 6 (deceptive read disturb): a read of the target bit returns the stored value, and then inverts the stored value.
- R8: Code 7 (incorrect read): a read of the target bit returns the inverse of the stored value and leaves the stored value unchanged.
- R9: Code 8 (write disturb): a write that stores into the target bit the value it already holds inverts the bit. A write of the opposite value takes effect normally.
- R10: A fault affects only bit `flt_bit` of word `flt_addr`. All other bits of that word, and all other words, behave as in R1.
- R11: The fault inputs are sampled only while `rst` is high. After reset, `rd_data` is 0. The target cell starts at 0, except under code 2, where it starts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the fault configuration |
| addr | input | AW | Word address for a read or a write |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| rd_en | input | 1 | Read request |
| flt_addr | input | AW | Address of the faulty word |
| flt_bit | input | $clog2(DW) | Bit position of the faulty cell inside that word |
| flt_kind | input | 4 | Fault code (see R1 and R3 to R9) |
| rd_data | output | DW | Registered read data |

## Verification
The assertions assume that the fault configuration captured during reset does not change until the next reset. They also assume that `rd_data` is judged only one cycle after a real read, with a write in the same cycle counting as no read. The bench changes `flt_*` only while `rst` is high. It writes each address before reading it, so no read of the word storage returns uninitialised data. For every fault code, it drives the target cell through both stored polarities with repeated reads and with transition and non-transition writes. Neighbouring bits and addresses are read between those operations.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;
  localparam int KW = 4;
  localparam logic [KW-1:0] FK_NONE      = 4'd0;
  localparam logic [KW-1:0] FK_SA0       = 4'd1;
  localparam logic [KW-1:0] FK_SA1       = 4'd2;
  localparam logic [KW-1:0] FK_TF_UP     = 4'd3;
  localparam logic [KW-1:0] FK_TF_DN     = 4'd4;
  localparam logic [KW-1:0] FK_RD_DIST   = 4'd5;
  localparam logic [KW-1:0] FK_RD_DECEPT = 4'd6;
  localparam logic [KW-1:0] FK_RD_WRONG  = 4'd7;
  localparam logic [KW-1:0] FK_WR_DIST   = 4'd8;

  function automatic logic kind_active(input logic [KW-1:0] k);
    return (k >= FK_SA0) && (k <= FK_WR_DIST);
  endfunction
endpackage

// File: rtl/fault_ram_store.sv
module fault_ram_store #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= d;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[a];
  end
endmodule

// File: rtl/fault_ram_cell.sv
module fault_ram_cell
  import fault_ram_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [KW-1:0] kind,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic          wbit,
  output logic          state,
  output logic          rd_bit_q
);
  logic state_q, state_d, rd_out;

  always_comb begin
    state_d = state_q;
    rd_out  = state_q;
    if (wr_hit) begin
      unique case (kind)
        FK_SA0:     state_d = 1'b0;
        FK_SA1:     state_d = 1'b1;
        FK_TF_UP:   state_d = (!state_q && wbit) ? 1'b0 : wbit;
        FK_TF_DN:   state_d = (state_q && !wbit) ? 1'b1 : wbit;
        FK_WR_DIST: state_d = (wbit == state_q) ? ~state_q : wbit;
        default:    state_d = wbit;
      endcase
    end else if (rd_hit) begin
      unique case (kind)
        FK_SA0:       rd_out = 1'b0;
        FK_SA1:       rd_out = 1'b1;
        FK_RD_DIST:   begin rd_out = ~state_q; state_d = ~state_q; end
        FK_RD_DECEPT: begin rd_out = state_q;  state_d = ~state_q; end
        FK_RD_WRONG:  rd_out = ~state_q;
        default:      rd_out = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= (kind == FK_SA1);
      rd_bit_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rd_hit) rd_bit_q <= rd_out;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/fault_ram.sv
module fault_ram
  import fault_ram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  localparam int BW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] flt_addr,
  input  logic [BW-1:0] flt_bit,
  input  logic [KW-1:0] flt_kind,
  output logic [DW-1:0] rd_data
);
  logic [AW-1:0] cfg_addr_q;
  logic [BW-1:0] cfg_bit_q;
  logic [KW-1:0] cfg_kind_q;
  logic [KW-1:0] cell_kind;
  logic          do_rd, tgt, hit_q, cell_rd, cell_state, cell_wbit;
  logic [DW-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_addr_q <= flt_addr;
      cfg_bit_q  <= flt_bit;
      cfg_kind_q <= flt_kind;
    end
  end

  // during reset the cell sees the incoming code so it resets to the right level
  assign cell_kind = rst ? flt_kind : cfg_kind_q;
  assign do_rd     = rd_en && !wr_en;
  assign tgt       = kind_active(cfg_kind_q) && (addr == cfg_addr_q);
  assign cell_wbit = wr_data[cfg_bit_q];

  fault_ram_store #(.AW(AW), .DW(DW)) u_store (
    .clk (clk),
    .rst (rst),
    .we  (wr_en),
    .re  (do_rd),
    .a   (addr),
    .d   (wr_data),
    .q   (store_q)
  );

  fault_ram_cell u_cell (
    .clk      (clk),
    .rst      (rst),
    .kind     (cell_kind),
    .wr_hit   (wr_en && tgt),
    .rd_hit   (do_rd && tgt),
    .wbit     (cell_wbit),
    .state    (cell_state),
    .rd_bit_q (cell_rd)
  );

  always_ff @(posedge clk) begin
    if (rst)        hit_q <= 1'b0;
    else if (do_rd) hit_q <= tgt;
  end

  for (genvar g = 0; g < DW; g++) begin : g_merge
    assign rd_data[g] = (hit_q && (cfg_bit_q == BW'(g))) ? cell_rd : store_q[g];
  end
endmodule

// File: rtl/fault_ram_chk.sv
module fault_ram_chk
  import fault_ram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic [AW-1:0] cfg_addr_q,
  input logic [BW-1:0] cfg_bit_q,
  input logic [KW-1:0] cfg_kind_q,
  input logic          cell_state
);
  logic rd_t, wr_t;
  assign rd_t = rd_en && !wr_en && (addr == cfg_addr_q);
  assign wr_t = wr_en && (addr == cfg_addr_q);

  // R11
  rst_clears_out_chk: assert property (@(posedge clk) rst |=> rd_data == '0);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  // R2
  wr_prio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> $stable(rd_data));
  // R3
  sa0_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_t && cfg_kind_q == FK_SA0) |=> !rd_data[cfg_bit_q]);
  // R3
  sa1_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_t && cfg_kind_q == FK_SA1) |=> rd_data[cfg_bit_q]);
  // R4
  tf_up_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_t && cfg_kind_q == FK_TF_UP && !cell_state && wr_data[cfg_bit_q]) |=> !cell_state);
  // R5
  tf_dn_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_t && cfg_kind_q == FK_TF_DN && cell_state && !wr_data[cfg_bit_q]) |=> cell_state);
  // R6
  rdf_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_t && cfg_kind_q == FK_RD_DIST) |=> (cell_state != $past(cell_state)) && (rd_data[cfg_bit_q] == cell_state));
  // R7
  drdf_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_t && cfg_kind_q == FK_RD_DECEPT) |=> (cell_state != $past(cell_state)) && (rd_data[cfg_bit_q] != cell_state));
  // R8
  irf_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_t && cfg_kind_q == FK_RD_WRONG) |=> $stable(cell_state) && (rd_data[cfg_bit_q] != cell_state));
  // R9
  wdf_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_t && cfg_kind_q == FK_WR_DIST && wr_data[cfg_bit_q] == cell_state) |=> cell_state != $past(cell_state));
endmodule

bind fault_ram fault_ram_chk #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .cfg_addr_q (cfg_addr_q),
  .cfg_bit_q  (cfg_bit_q),
  .cfg_kind_q (cfg_kind_q),
  .cell_state (cell_state)
);

// File: tb/fault_ram_bench.sv
module fault_ram_bench;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] flt_addr = '0;
  logic [BW-1:0] flt_bit = '0;
  logic [3:0]    flt_kind = '0;
  logic [DW-1:0] rd_data;

  always #10 clk = ~clk;

  fault_ram #(.AW(AW), .DW(DW)) u_fault_ram (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .flt_addr(flt_addr), .flt_bit(flt_bit), .flt_kind(flt_kind),
    .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [1 << AW];
  logic [DW-1:0] m_exp;
  logic          m_cell;
  int            m_kind, m_addr, m_bit;

  task automatic compare(input string tag);
    checks++;
    if (rd_data !== m_exp) begin
      errors++;
      $display("FAIL %s rd_data=%h expected=%h at %0t", tag, rd_data, m_exp, $time);
    end
  endtask

  task automatic do_reset(input int k, input int ta, input int tb);
    rst = 1'b1; wr_en = 0; rd_en = 0;
    flt_kind = 4'(k); flt_addr = AW'(ta); flt_bit = BW'(tb);
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    m_kind = k; m_addr = ta; m_bit = tb;
    m_cell = (k == 2); m_exp = '0;
    flt_kind = 4'd0; flt_addr = '0; flt_bit = '0;  // ignored after reset (R11)
    @(posedge clk); #2;
    compare("R11");
  endtask

  task automatic op(input logic w, input logic r, input int a, input logic [DW-1:0] d, input string tag);
    logic act, b, o;
    logic [DW-1:0] v;
    wr_en = w; rd_en = r; addr = AW'(a); wr_data = d;
    @(posedge clk); #2;
    act = (m_kind >= 1 && m_kind <= 8) && (a == m_addr);
    if (w) begin
      m_mem[a] = d;
      if (act) begin
        b = d[m_bit];
        case (m_kind)
          1: m_cell = 0;
          2: m_cell = 1;
          3: if (!(m_cell == 0 && b == 1)) m_cell = b;
          4: if (!(m_cell == 1 && b == 0)) m_cell = b;
          8: m_cell = (b == m_cell) ? ~m_cell : b;
          default: m_cell = b;
        endcase
      end
    end else if (r) begin
      v = m_mem[a];
      if (act) begin
        o = m_cell;
        case (m_kind)
          1: o = 0;
          2: o = 1;
          5: begin o = ~m_cell; m_cell = ~m_cell; end
          6: begin o = m_cell;  m_cell = ~m_cell; end
          7: o = ~m_cell;
          default: ;
        endcase
        v[m_bit] = o;
      end
      m_exp = v;
    end
    wr_en = 0; rd_en = 0;
    compare(tag);
  endtask

  task automatic fault_seq(input int k, input string tag);
    do_reset(k, 5, 3);
    op(1, 0, 5, 8'h00, tag);
    op(1, 0, 6, 8'hA5, "R10");
    op(0, 1, 5, 8'h00, tag);
    op(0, 1, 5, 8'h00, tag);
    op(1, 0, 5, 8'hFF, tag);   // 0 -> 1 write
    op(0, 1, 5, 8'h00, tag);
    op(0, 1, 5, 8'h00, tag);
    op(0, 1, 6, 8'h00, "R10");
    op(1, 0, 5, 8'hF7, tag);   // target bit 0
    op(1, 0, 5, 8'hF7, tag);   // repeat same value
    op(0, 1, 5, 8'h00, tag);
    op(1, 0, 5, 8'h08, tag);
    op(1, 0, 5, 8'h08, tag);
    op(0, 1, 5, 8'h00, tag);
    op(0, 1, 5, 8'h00, tag);
    op(1, 0, 5, 8'h00, tag);   // 1 -> 0 write
    op(0, 1, 5, 8'h00, tag);
    op(0, 0, 5, 8'h00, tag);   // idle
    op(0, 1, 6, 8'h00, "R10");
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
    // R1 ideal behaviour and R2 write priority
    do_reset(0, 5, 3);
    for (int i = 0; i < 8; i++) op(1, 0, i, 8'(i * 37 + 1), "R1");
    for (int i = 0; i < 8; i++) op(0, 1, i, 8'h00, "R1");
    op(0, 0, 2, 8'h00, "R1");
    op(1, 1, 3, 8'h5A, "R2");
    op(0, 1, 3, 8'h00, "R2");
    do_reset(12, 5, 3);
    op(1, 0, 5, 8'h3C, "R1");
    op(0, 1, 5, 8'h00, "R1");
    fault_seq(1, "R3");
    fault_seq(2, "R3");
    fault_seq(3, "R4");
    fault_seq(4, "R5");
    fault_seq(5, "R6");
    fault_seq(6, "R7");
    fault_seq(7, "R8");
    fault_seq(8, "R9");
    // R10: other bit position and address
    do_reset(7, 60, 0);
    op(1, 0, 60, 8'hF0, "R10");
    op(1, 0, 61, 8'hF0, "R10");
    op(0, 1, 60, 8'h00, "R10");
    op(0, 1, 61, 8'h00, "R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule